// File: doc/BRIEF.md
# UART Baud Clock Generator

This block makes the oversampling tick that paces both the transmitter and the receiver of one serial channel. The reference clock first goes through a prescaler that divides by 1 or by 4. A 16-bit programmable divisor then divides it again. The divisor is loaded one byte at a time through a small write port. A divisor of zero stops the generator, and no ticks are emitted while it is zero.

A mode input selects 16x or 8x oversampling. The block emits a one-cycle `sample_tick` at the oversampling rate and a one-cycle `bit_tick` once per serial bit period. It also reports how many sample ticks make up one bit: 16 or 8.

A new divisor value takes effect only when the current count period ends. A host can therefore rewrite the rate while the channel is running, and the period in progress is never cut short or stretched.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor holds zero, both tick outputs are low, and no tick appears until a nonzero divisor is written.
- R2: With the prescaler at divide-by-1 and divisor D (D ≥ 1), `sample_tick` pulses for one cycle every D clock cycles.
- R3: With `presc_div4` = 1, the prescaler passes only every 4th clock cycle, so `sample_tick` pulses every 4·D clock cycles.
- R4: A write with `wr_addr` = 0 loads divisor bits 7:0, and a write with `wr_addr` = 1 loads bits 15:8. For example, low byte 0x02 with high byte 0x01 gives D = 258.
- R5: Once the divisor is zero and the period in progress has ended, no `sample_tick` or `bit_tick` is emitted.
- R6: A divisor written partway through a period does not alter that period. The new value governs the count from the next period onwards.
- R7: With `os_16x` = 1, `bit_tick` pulses on every 16th sample tick, so its spacing is 16·D·prescale cycles, and `bit_samples` reads 16.
- R8: With `os_16x` = 0, `bit_tick` pulses on every 8th sample tick, so its spacing is 8·D·prescale cycles, and `bit_samples` reads 8.
- R9: `bit_tick` is high only in a cycle in which `sample_tick` is also high.
- R10: With D = 1 and divide-by-1, `sample_tick` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_addr | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| wr_data | input | 8 | Divisor byte value |
| presc_div4 | input | 1 | 1 = prescaler divides by 4, 0 = divides by 1 |
| os_16x | input | 1 | 1 = 16x oversampling, 0 = 8x |
| sample_tick | output | 1 | One-cycle oversampling pulse |
| bit_tick | output | 1 | One-cycle pulse per serial bit period |
| bit_samples | output | 5 | Sample ticks per bit (16 or 8) |

## Verification
A corrupted down-counter or active divisor shows up as a wrong gap between two `sample_tick` pulses. The error is visible within one period of the measured spacing. A fault in the byte steering or the zero-stop handling shows as a wrong long spacing, or as pulses that continue after the divisor is cleared. A fault in the bit counter shifts the `bit_tick` spacing away from exactly 16 or 8 sample ticks, or produces a `bit_tick` without a matching `sample_tick`, so the bench measures both spacings directly. A reload taken at the wrong moment changes the length of the period that was running when the write arrived, so the bench measures that period separately.

// File: rtl/baud_pkg.sv
package baud_pkg;
   localparam int unsigned BAUD_BYTE_W = 8;

   function automatic int unsigned baud_addr_w(input int unsigned nbytes);
      return (nbytes > 1) ? $clog2(nbytes) : 1;
   endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
   parameter int unsigned RATIO = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic div_en,
   output logic pre_tick
);
   if (RATIO < 1) begin : g_bad_ratio
      $error("baud_prescaler: RATIO must be at least 1");
   end

   if (RATIO == 1) begin : g_pass
      assign pre_tick = 1'b1;
   end else begin : g_count
      localparam int unsigned PW = $clog2(RATIO);
      localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
      logic [PW-1:0] pcnt;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pcnt <= '0;
         end else if (pcnt == LAST) begin
            pcnt <= '0;
         end else begin
            pcnt <= pcnt + 1'b1;
         end
      end

      assign pre_tick = !div_en || (pcnt == LAST);

      AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
         (div_en && pre_tick) ##1 div_en |-> !pre_tick); // R3
   end
endmodule

// File: rtl/baud_divider.sv
module baud_divider
   import baud_pkg::*;
#(
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned BYTE_W = BAUD_BYTE_W,
   localparam int unsigned NBYTES = DIV_W / BYTE_W,
   localparam int unsigned AW     = baud_addr_w(DIV_W / BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pre_tick,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              tick_next,
   output logic              sample_tick
);
   if (DIV_W % BYTE_W != 0 || NBYTES < 1) begin : g_bad_width
      $error("baud_divider: DIV_W must be a multiple of BYTE_W");
   end

   logic [DIV_W-1:0] shadow;
   logic [DIV_W-1:0] act_div;
   logic [DIV_W-1:0] cnt;
   logic             running;
   logic             shadow_nz;
   logic [DIV_W-1:0] reload_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (wr_en) begin
         for (int b = 0; b < NBYTES; b++) begin
            if (wr_addr == AW'(b)) begin
               shadow[b*BYTE_W +: BYTE_W] <= wr_data;
            end
         end
      end
   end

   assign running    = (act_div != '0);
   assign shadow_nz  = (shadow != '0);
   assign reload_cnt = shadow_nz ? shadow - 1'b1 : '0;
   assign tick_next  = running && pre_tick && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_div     <= '0;
         cnt         <= '0;
         sample_tick <= 1'b0;
      end else begin
         sample_tick <= tick_next;
         if (!running) begin
            if (shadow_nz) begin
               act_div <= shadow;
               cnt     <= reload_cnt;
            end
         end else if (pre_tick) begin
            if (cnt == '0) begin
               act_div <= shadow;
               cnt     <= reload_cnt;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt < act_div)); // R2
   AST_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == '0) |=> (shadow[BYTE_W-1:0] == $past(wr_data))); // R4
   AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !shadow_nz) |=> !sample_tick); // R5
endmodule

// File: rtl/baud_bitcnt.sv
module baud_bitcnt #(
   parameter int unsigned OS_HI = 16,
   parameter int unsigned OS_LO = 8,
   localparam int unsigned CW = $clog2(OS_HI),
   localparam int unsigned BW = $clog2(OS_HI + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sample_next,
   input  logic          mode_hi,
   output logic          bit_tick,
   output logic [BW-1:0] bit_samples
);
   if (OS_LO < 2 || OS_LO >= OS_HI) begin : g_bad_os
      $error("baud_bitcnt: need 2 <= OS_LO < OS_HI");
   end

   logic [CW-1:0] bcnt;
   logic [CW-1:0] last;
   logic          wrap;

   assign last        = mode_hi ? CW'(OS_HI - 1) : CW'(OS_LO - 1);
   assign wrap        = (bcnt >= last);
   assign bit_samples = mode_hi ? BW'(OS_HI) : BW'(OS_LO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bcnt     <= '0;
         bit_tick <= 1'b0;
      end else begin
         bit_tick <= sample_next && wrap;
         if (sample_next) begin
            bcnt <= wrap ? '0 : bcnt + 1'b1;
         end
      end
   end

   AST_BIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> (bcnt == '0)); // R7
   AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_next && !mode_hi && bcnt < CW'(OS_LO)) |=> (bcnt < CW'(OS_LO))); // R8
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_pkg::*;
#(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned PRESC_RATIO = 4,
   parameter int unsigned OS_HI       = 16,
   parameter int unsigned OS_LO       = 8,
   localparam int unsigned BYTE_W = BAUD_BYTE_W,
   localparam int unsigned AW     = baud_addr_w(DIV_W / BAUD_BYTE_W),
   localparam int unsigned BW     = $clog2(OS_HI + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              presc_div4,
   input  logic              os_16x,
   output logic              sample_tick,
   output logic              bit_tick,
   output logic [BW-1:0]     bit_samples
);
   logic pre_tick;
   logic tick_next;

   baud_prescaler #(.RATIO(PRESC_RATIO)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_en   (presc_div4),
      .pre_tick (pre_tick)
   );

   baud_divider #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .pre_tick    (pre_tick),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .tick_next   (tick_next),
      .sample_tick (sample_tick)
   );

   baud_bitcnt #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_bits (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_next (tick_next),
      .mode_hi     (os_16x),
      .bit_tick    (bit_tick),
      .bit_samples (bit_samples)
   );

   AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> sample_tick); // R9
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!sample_tick && !bit_tick)); // R1
endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
   localparam int LIM = 5000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [0:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       presc_div4 = 1'b0;
   logic       os_16x = 1'b1;
   logic       sample_tick;
   logic       bit_tick;
   logic [4:0] bit_samples;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   baud_tick_gen dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .presc_div4(presc_div4), .os_16x(os_16x),
      .sample_tick(sample_tick), .bit_tick(bit_tick), .bit_samples(bit_samples)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_div(input int d);
      wr(1'b0, d[7:0]);
      wr(1'b1, d[15:8]);
   endtask

   function automatic logic pick(input bit use_bit);
      return use_bit ? bit_tick : sample_tick;
   endfunction

   // spacing in cycles between two consecutive pulses; -1 on timeout
   task automatic gap(input bit use_bit, output int g);
      int n;
      g = -1;
      n = 0;
      @(negedge clk);
      while (!pick(use_bit) && n < LIM) begin @(negedge clk); n++; end
      if (n >= LIM) return;
      if (use_bit) chk("R9 sample_tick with bit_tick", int'(sample_tick), 1);
      n = 1;
      @(negedge clk);
      while (!pick(use_bit) && n < LIM) begin @(negedge clk); n++; end
      if (n >= LIM) return;
      if (use_bit) chk("R9 sample_tick with bit_tick", int'(sample_tick), 1);
      g = n;
   endtask

   task automatic count_pulses(input int cycles, output int s, output int b);
      s = 0; b = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         s += int'(sample_tick);
         b += int'(bit_tick);
      end
   endtask

   task automatic t_reset();
      int s, b;
      chk("R1 sample_tick after reset", int'(sample_tick), 0);
      chk("R1 bit_tick after reset", int'(bit_tick), 0);
      chk("R7 bit_samples 16x", int'(bit_samples), 16);
      count_pulses(100, s, b);
      chk("R1 no sample ticks with reset divisor", s, 0);
      chk("R1 no bit ticks with reset divisor", b, 0);
   endtask

   task automatic t_div1();
      int g;
      set_div(5);
      gap(0, g);
      gap(0, g);
      chk("R2 sample spacing D=5", g, 5);
      gap(0, g);
      chk("R2 sample spacing D=5 repeat", g, 5);
   endtask

   task automatic t_bytes();
      int g;
      wr(1'b0, 8'h02);
      wr(1'b1, 8'h01);
      gap(0, g);
      gap(0, g);
      chk("R4 byte assembly D=258", g, 258);
   endtask

   task automatic t_prescale();
      int g;
      set_div(5);
      presc_div4 = 1'b1;
      gap(0, g);
      gap(0, g);
      chk("R3 divide-by-4 spacing", g, 20);
      presc_div4 = 1'b0;
   endtask

   task automatic t_bit16();
      int g;
      os_16x = 1'b1;
      set_div(3);
      gap(1, g);
      gap(1, g);
      chk("R7 bit spacing 16x D=3", g, 48);
   endtask

   task automatic t_bit8();
      int g;
      os_16x = 1'b0;
      set_div(3);
      @(negedge clk);
      chk("R8 bit_samples 8x", int'(bit_samples), 8);
      gap(1, g);
      gap(1, g);
      chk("R8 bit spacing 8x D=3", g, 24);
      presc_div4 = 1'b1;
      gap(1, g);
      gap(1, g);
      chk("R8 bit spacing 8x D=3 div4", g, 96);
      presc_div4 = 1'b0;
      os_16x = 1'b1;
   endtask

   task automatic t_one();
      int s, b, g;
      set_div(1);
      gap(0, g);
      count_pulses(40, s, b);
      chk("R10 continuous sample ticks", s, 40);
      gap(1, g);
      gap(1, g);
      chk("R7 bit spacing 16x D=1", g, 16);
   endtask

   task automatic t_reload();
      int g, n;
      set_div(40);
      gap(0, g);
      gap(0, g);
      chk("R6 steady spacing D=40", g, 40);
      // g ended on a pulse; write new value early in the next period
      wr(1'b0, 8'd12);
      wr(1'b1, 8'd0);
      n = 4;
      @(negedge clk); n++;
      while (!sample_tick && n < LIM) begin @(negedge clk); n++; end
      chk("R6 period in progress keeps old length", n, 40);
      n = 1;
      @(negedge clk);
      while (!sample_tick && n < LIM) begin @(negedge clk); n++; end
      chk("R6 next period uses new divisor", n, 12);
   endtask

   task automatic t_stop();
      int s, b;
      set_div(0);
      count_pulses(300, s, b);
      count_pulses(500, s, b);
      chk("R5 no sample ticks when divisor zero", s, 0);
      chk("R5 no bit ticks when divisor zero", b, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_div1();
      t_bytes();
      t_prescale();
      t_bit16();
      t_bit8();
      t_one();
      t_reload();
      t_stop();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule